// File: doc/BRIEF.md
# Multi-Channel Event Comparator Bank

A bank of independent comparator channels that all watch one shared free-running 64-bit count. Each channel acts as a per-core event timer. Software loads a period and selects one-shot or circular operation, then arms the channel. On arming, the channel captures a target equal to the count at that moment plus the period. When the count reaches or passes the target, the channel latches a pending event and drives its own interrupt line while the event is unmasked.

The enable bit is not seen at once. The written value passes through a short synchronizer chain, and software polls the enable register until the read-back matches the value it wrote. In circular mode a match moves the target forward by one period and the channel stays armed. In one-shot mode a match leaves the channel idle until software disarms and re-arms it. While a channel is enabled, or while an enable change is still in flight, the channel ignores writes to its configuration. Software clears a pending event by writing 1 to the status register.

Top module: `evt_cmp_bank`

## Requirements
- R1: The register map and its read behaviour are as follows.
  - Channel c (0 to N_CH-1, default 12) owns a 0x100-byte window at byte address 0x200 + c*0x100.
  - The word offsets in the window are: 0x00 target bits 31:0, 0x04 target bits 63:32, 0x08 mode (bit 0), 0x0C period, 0x10 enable (bit 0), 0x14 interrupt enable (bit 0), 0x18 status (bit 0).
  - A read of any other address returns 0.
- R2: After reset the following hold.
  - Every irq_o bit is 0.
  - Enable, mode, interrupt enable, status and target all read 0.
  - Period reads 0x0000000F.
- R3: Enable read-back follows a write to the enable register after three rising clock edges.
  - Count the edge that takes the write as edge 0.
  - The read-back still shows the old value after edges 1 and 2, and shows the new value after edge 3.
- R4: Arming happens on the edge where the enable read-back turns to 1. On that edge the target is set to cnt_i plus the period, and it reads back through offsets 0x00 and 0x04.
- R5: Matching and interrupt output work as follows.
  - While armed, a count with cnt_i >= target sets the status bit on the next edge. A count below the target does not.
  - irq_o[c] is 1 exactly when that channel's status bit and interrupt enable bit are both 1.
- R6: Mode 0 (one-shot) ends on its first match. The channel raises no further event, even when the count moves past the target, until it is re-armed.
- R7: Mode 1 (circular) continues after each match. Each match adds the period to the target, and the channel stays armed for the next match.
- R8: The status register has these write rules.
  - Writing 1 to bit 0 clears the status bit. Writing 0 has no effect.
  - When a match and a clear fall on the same edge, the match wins.
- R9: Writes to target, mode or period are ignored while the channel is busy. A channel is busy when the enable register holds 1 or any stage of the enable synchronizer, including the read-back, is 1.
- R10: A written period is clamped into the range 0x0000000F to 0x7FFFFFFF, and the clamped value is the one that reads back.
- R11: Writing 0 to enable disarms the channel once the read-back reaches 0. After that no event is raised, whatever the count does.
- R12: The channels are independent. An event on one channel changes no other channel's status or irq_o bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 64 | Shared free-running count |
| we_i | input | 1 | Register write strobe, taken on the rising edge |
| addr_i | input | ADDR_W (12) | Byte address for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | N_CH (12) | Per-channel interrupt lines |

## Verification
The bound checker tests four properties on every cycle:
- an interrupt line can never be high while its enable bit is masked;
- a pending status bit holds until a write-one clear;
- every match sets status on the next edge;
- a one-shot match always leaves the channel disarmed.

It also checks on every cycle that the period cannot move while the channel is busy.

Several behaviours only show up in the bench's scenarios, because they depend on exact values and edge counts. These are:
- the three-edge enable latency;
- the captured target value and the one-period advance in circular mode;
- period clamping;
- the silence after a disarm;
- the isolation between channels.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;
  localparam int unsigned WIN_BASE   = 32'h200;
  localparam int unsigned WIN_SHIFT  = 8;
  localparam logic [31:0] PER_MIN    = 32'h0000_000F;
  localparam logic [31:0] PER_MAX    = 32'h7FFF_FFFF;

  typedef enum logic [7:0] {
    OFF_TGT_LO = 8'h00,
    OFF_TGT_HI = 8'h04,
    OFF_MODE   = 8'h08,
    OFF_PER    = 8'h0C,
    OFF_EN     = 8'h10,
    OFF_IE     = 8'h14,
    OFF_STAT   = 8'h18
  } reg_off_e;

  function automatic logic [31:0] clamp_period(input logic [31:0] w);
    if (w < PER_MIN)      return PER_MIN;
    else if (w > PER_MAX) return PER_MAX;
    else                  return w;
  endfunction
endpackage

// File: rtl/evt_cmp_sync.sv
module evt_cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[s] <= 1'b0;
        else if (s == 0) sr_q[s] <= d_i;
        else sr_q[s] <= sr_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/evt_cmp_chan.sv
module evt_cmp_chan
  import evt_cmp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [63:0] cnt_i,
  input  logic        we_i,
  input  logic [7:0]  off_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        st_o,
  output logic        ie_o,
  output logic        hit_o,
  output logic        mode_o,
  output logic        armed_o,
  output logic        busy_o,
  output logic [31:0] per_o
);
  logic [63:0] tgt_q;
  logic [31:0] per_q;
  logic        mode_q, ie_q, st_q, en_req_q, ack_q, armed_q;
  logic        en_sync;
  logic        arm_pulse, hit, busy;

  evt_cmp_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (en_req_q),
    .q_o    (en_sync)
  );

  assign arm_pulse = en_sync & ~ack_q;
  assign hit       = armed_q & (cnt_i >= tgt_q);
  assign busy      = en_req_q | en_sync | ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_req_q <= 1'b0;
      ack_q    <= 1'b0;
      ie_q     <= 1'b0;
    end else begin
      ack_q <= en_sync;
      if (we_i && off_i == OFF_EN) en_req_q <= wdata_i[0];
      if (we_i && off_i == OFF_IE) ie_q     <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= PER_MIN;
      mode_q <= 1'b0;
    end else if (we_i && !busy) begin
      if (off_i == OFF_PER)  per_q  <= clamp_period(wdata_i);
      if (off_i == OFF_MODE) mode_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0;
    end else if (arm_pulse) begin
      tgt_q <= cnt_i + {32'b0, per_q};
    end else if (hit && mode_q) begin
      tgt_q <= tgt_q + {32'b0, per_q};
    end else if (we_i && !busy) begin
      if (off_i == OFF_TGT_LO) tgt_q[31:0]  <= wdata_i;
      if (off_i == OFF_TGT_HI) tgt_q[63:32] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             armed_q <= 1'b0;
    else if (arm_pulse)      armed_q <= 1'b1;
    else if (!en_sync)       armed_q <= 1'b0;
    else if (hit && !mode_q) armed_q <= 1'b0;
  end

  // a match on the same edge as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= 1'b0;
    else if (hit) st_q <= 1'b1;
    else if (we_i && off_i == OFF_STAT && wdata_i[0]) st_q <= 1'b0;
  end

  always_comb begin
    unique case (off_i)
      OFF_TGT_LO: rdata_o = tgt_q[31:0];
      OFF_TGT_HI: rdata_o = tgt_q[63:32];
      OFF_MODE:   rdata_o = {31'b0, mode_q};
      OFF_PER:    rdata_o = per_q;
      OFF_EN:     rdata_o = {31'b0, ack_q};
      OFF_IE:     rdata_o = {31'b0, ie_q};
      OFF_STAT:   rdata_o = {31'b0, st_q};
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o   = st_q & ie_q;
  assign st_o    = st_q;
  assign ie_o    = ie_q;
  assign hit_o   = hit;
  assign mode_o  = mode_q;
  assign armed_o = armed_q;
  assign busy_o  = busy;
  assign per_o   = per_q;
endmodule

// File: rtl/evt_cmp_bank.sv
module evt_cmp_bank
  import evt_cmp_pkg::*;
#(
  parameter int unsigned N_CH        = 12,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [63:0]       cnt_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  localparam int unsigned IDX_W = ADDR_W - WIN_SHIFT;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(WIN_BASE);

  logic              in_win;
  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        off;

  logic [N_CH-1:0]    we_ch, clr_vec, st_vec, ie_vec, hit_vec, mode_vec, armed_vec, busy_vec;
  logic [N_CH*32-1:0] per_flat;
  logic [31:0]        rd_ch [N_CH];

  assign in_win = addr_i >= BASE_A;
  assign rel    = addr_i - BASE_A;
  assign idx    = rel[ADDR_W-1:WIN_SHIFT];
  assign off    = rel[WIN_SHIFT-1:0];

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
      assign we_ch[g]   = we_i && in_win && (idx == IDX_W'(g));
      assign clr_vec[g] = we_ch[g] && (off == OFF_STAT) && wdata_i[0];

      evt_cmp_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cnt_i   (cnt_i),
        .we_i    (we_ch[g]),
        .off_i   (off),
        .wdata_i (wdata_i),
        .rdata_o (rd_ch[g]),
        .irq_o   (irq_o[g]),
        .st_o    (st_vec[g]),
        .ie_o    (ie_vec[g]),
        .hit_o   (hit_vec[g]),
        .mode_o  (mode_vec[g]),
        .armed_o (armed_vec[g]),
        .busy_o  (busy_vec[g]),
        .per_o   (per_flat[g*32 +: 32])
      );
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (in_win && idx == IDX_W'(i)) rdata_o = rd_ch[i];
    end
  end
endmodule

// File: rtl/evt_cmp_bank_chk.sv
module evt_cmp_bank_chk #(
  parameter int unsigned N_CH = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_CH-1:0]    irq_o,
  input logic [N_CH-1:0]    ie_vec,
  input logic [N_CH-1:0]    st_vec,
  input logic [N_CH-1:0]    clr_vec,
  input logic [N_CH-1:0]    hit_vec,
  input logic [N_CH-1:0]    mode_vec,
  input logic [N_CH-1:0]    armed_vec,
  input logic [N_CH-1:0]    busy_vec,
  input logic [N_CH*32-1:0] per_flat
);
  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_chk
      assert_irq_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ie_vec[i] |-> !irq_o[i]);
      assert_hit_sets_status_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_vec[i] |=> st_vec[i]);
      assert_status_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_vec[i] && !clr_vec[i]) |=> st_vec[i]);
      assert_oneshot_stops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_vec[i] && !mode_vec[i]) |=> !armed_vec[i]);
      assert_period_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_vec[i] |=> $stable(per_flat[i*32 +: 32]));
    end
  endgenerate
endmodule

bind evt_cmp_bank evt_cmp_bank_chk #(.N_CH(N_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_o     (irq_o),
  .ie_vec    (ie_vec),
  .st_vec    (st_vec),
  .clr_vec   (clr_vec),
  .hit_vec   (hit_vec),
  .mode_vec  (mode_vec),
  .armed_vec (armed_vec),
  .busy_vec  (busy_vec),
  .per_flat  (per_flat)
);

// File: tb/sim_evt_cmp_bank.sv
`timescale 1ns/1ps
module sim_evt_cmp_bank;
  localparam int N_CH = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] cnt_i = '0;
  logic        we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [N_CH-1:0] irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  evt_cmp_bank u0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  function automatic logic [11:0] ra(input int ch, input int off);
    return 12'(32'h200 + ch * 32'h100 + off);
  endfunction

  function automatic logic [31:0] exp_clamp(input logic [31:0] p);
    if (p < 32'hF) return 32'hF;
    if (p > 32'h7FFF_FFFF) return 32'h7FFF_FFFF;
    return p;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic rd_tgt(input int ch, output logic [63:0] t);
    logic [31:0] lo, hi;
    rd(ra(ch, 8'h00), lo);
    rd(ra(ch, 8'h04), hi);
    t = {hi, lo};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t, tg;
    void'($urandom(32'h5EED_1234));
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // reset state
    check("R2 irq", 64'(irq_o), 64'h0);
    rd(ra(0, 8'h0C), d); check("R2 period", 64'(d), 64'hF);
    rd(ra(5, 8'h10), d); check("R2 enable", 64'(d), 64'h0);
    rd(ra(11, 8'h18), d); check("R2 status", 64'(d), 64'h0);
    rd_tgt(3, t); check("R2 target", t, 64'h0);

    // map holes
    rd(12'h100, d); check("R1 below window", 64'(d), 64'h0);
    rd(ra(0, 8'h1C), d); check("R1 unused offset", 64'(d), 64'h0);

    // clamp
    wr(ra(1, 8'h0C), 32'h3);         rd(ra(1, 8'h0C), d); check("R10 low", 64'(d), 64'hF);
    wr(ra(1, 8'h0C), 32'hFFFF_FFFF); rd(ra(1, 8'h0C), d); check("R10 high", 64'(d), 64'h7FFF_FFFF);
    wr(ra(1, 8'h0C), 32'h20);        rd(ra(1, 8'h0C), d); check("R10 mid", 64'(d), 64'h20);

    // directed one-shot on channel 2
    cnt_i = 64'd1000;
    wr(ra(2, 8'h0C), 32'h20);
    wr(ra(2, 8'h08), 32'h0);
    wr(ra(2, 8'h14), 32'h1);
    wr(ra(2, 8'h10), 32'h1);
    rd(ra(2, 8'h10), d); check("R3 edge0", 64'(d), 64'h0);
    idle(1); rd(ra(2, 8'h10), d); check("R3 edge1", 64'(d), 64'h0);
    idle(1); rd(ra(2, 8'h10), d); check("R3 edge2", 64'(d), 64'h0);
    idle(1); rd(ra(2, 8'h10), d); check("R3 edge3", 64'(d), 64'h1);
    rd_tgt(2, t); check("R4 target", t, 64'd1032);
    wr(ra(2, 8'h0C), 32'h55); rd(ra(2, 8'h0C), d); check("R9 period", 64'(d), 64'h20);
    wr(ra(2, 8'h08), 32'h1);  rd(ra(2, 8'h08), d); check("R9 mode", 64'(d), 64'h0);
    wr(ra(2, 8'h00), 32'h7);  rd_tgt(2, t); check("R9 target", t, 64'd1032);
    cnt_i = 64'd1031; idle(1);
    rd(ra(2, 8'h18), d); check("R5 below", 64'(d), 64'h0);
    check("R5 irq below", 64'(irq_o), 64'h0);
    cnt_i = 64'd1032; idle(1);
    rd(ra(2, 8'h18), d); check("R5 match", 64'(d), 64'h1);
    check("R12 irq only ch2", 64'(irq_o), 64'h4);
    wr(ra(2, 8'h18), 32'h0); rd(ra(2, 8'h18), d); check("R8 write0", 64'(d), 64'h1);
    wr(ra(2, 8'h14), 32'h0); check("R5 masked", 64'(irq_o), 64'h0);
    wr(ra(2, 8'h14), 32'h1); check("R5 unmasked", 64'(irq_o), 64'h4);
    wr(ra(2, 8'h18), 32'h1); rd(ra(2, 8'h18), d); check("R8 clear", 64'(d), 64'h0);
    check("R8 irq cleared", 64'(irq_o), 64'h0);
    cnt_i = 64'd1037; idle(2);
    rd(ra(2, 8'h18), d); check("R6 no refire", 64'(d), 64'h0);
    wr(ra(2, 8'h10), 32'h0); idle(3);
    rd(ra(2, 8'h10), d); check("R11 readback", 64'(d), 64'h0);

    // random scenarios
    for (int it = 0; it < 40; it++) begin
      int ch;
      logic [31:0] per;
      logic        md;
      ch  = int'($urandom % N_CH);
      per = 32'hF + ($urandom % 32'h400);
      md  = 1'($urandom % 2);
      cnt_i = {32'h0, $urandom};
      wr(ra(ch, 8'h0C), per);
      wr(ra(ch, 8'h08), {31'b0, md});
      wr(ra(ch, 8'h14), 32'h1);
      wr(ra(ch, 8'h10), 32'h1);
      idle(3);
      rd(ra(ch, 8'h10), d); check("R3 armed", 64'(d), 64'h1);
      rd_tgt(ch, t); tg = cnt_i + 64'(per);
      check("R4 random target", t, tg);
      cnt_i = tg - 64'd1; idle(1);
      rd(ra(ch, 8'h18), d); check("R5 random below", 64'(d), 64'h0);
      cnt_i = tg; idle(1);
      rd(ra(ch, 8'h18), d); check("R5 random match", 64'(d), 64'h1);
      check("R12 random irq", 64'(irq_o), 64'(1) << ch);
      wr(ra(ch, 8'h18), 32'h1);
      if (md) begin
        rd_tgt(ch, t); check("R7 advance", t, tg + 64'(per));
        cnt_i = tg + 64'(per); idle(1);
        rd(ra(ch, 8'h18), d); check("R7 second match", 64'(d), 64'h1);
        wr(ra(ch, 8'h18), 32'h1);
      end else begin
        cnt_i = tg + 64'(per); idle(2);
        rd(ra(ch, 8'h18), d); check("R6 one-shot idle", 64'(d), 64'h0);
      end
      wr(ra(ch, 8'h10), 32'h0); idle(3);
      rd(ra(ch, 8'h10), d); check("R11 disarmed", 64'(d), 64'h0);
      wr(ra(ch, 8'h18), 32'h1);
      cnt_i = cnt_i + 64'(per) * 64'd10; idle(2);
      rd(ra(ch, 8'h18), d); check("R11 silent", 64'(d), 64'h0);
      check("R11 irq silent", 64'(irq_o), 64'h0);
      wr(ra(ch, 8'h0C), 32'h5); rd(ra(ch, 8'h0C), d);
      check("R10 random clamp", 64'(d), 64'(exp_clamp(32'h5)));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule